// File: doc/BRIEF.md
# Priority Set-Reset Control Latch

This block is the bistable element at the heart of a timer's control path, rebuilt as a clocked digital circuit. It has three asynchronous control inputs: an active-low master clear, an active-high threshold reset and an active-low trigger set. Each input crosses into the clock domain through its own synchronizer chain. A small two-state machine then decides whether the stored state is set, cleared or kept.

The block drives two outputs. The first is a push-pull level equal to the stored state. The second is an open-drain discharge path, given as a drive-enable plus a data bit that is always zero. The discharge path pulls low whenever the state is low and floats whenever the state is high.

The master clear always wins. A strap input, captured only while the system reset is held, sets which of threshold and trigger prevails when both are asserted at once. States: `ST_LOW` (cleared) and `ST_HIGH` (set). Transitions: `ST_LOW -> ST_HIGH` on a set decision; `ST_HIGH -> ST_LOW` on a clear decision; every other case holds the current state.

Top module: `prio_sr_latch`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `q_o` is 0 and `dis_oe_o` is 1 (state `ST_LOW`).
- R2: A low on `clr_n_i` drives `q_o` to 0, whatever `thr_i`, `trg_n_i` and the captured mode are.
- R3: A high on `thr_i` while `trg_n_i` is high (trigger inactive) and `clr_n_i` is high drives `q_o` to 0.
- R4: A low on `trg_n_i` while `clr_n_i` is high and `thr_i` is low drives `q_o` to 1.
- R5: Once set, `q_o` stays 1 after `trg_n_i` returns high, as long as `clr_n_i` stays high and `thr_i` stays low.
- R6: Once cleared, `q_o` stays 0 after `clr_n_i` or `thr_i` is released, as long as `trg_n_i` stays high.
- R7: With the captured mode 0 (reset wins), `thr_i` high and `trg_n_i` low together drive `q_o` to 0.
- R8: With the captured mode 1 (set wins), `thr_i` high and `trg_n_i` low together drive `q_o` to 1. A low `clr_n_i` still forces 0 in this mode.
- R9: `dis_oe_o` is always the inverse of `q_o`, and `dis_o` is always 0.
- R10: An input change seen by the first synchronizer flop at clock edge k shows on `q_o` after edge k+SYNC_STAGES, and not before.
- R11: `mode_i` is captured only while `rst` is high. Changes to it during operation have no effect on how a threshold/trigger conflict is resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high system reset |
| mode_i | input | 1 | Conflict strap: 0 = reset wins, 1 = set wins; captured during reset |
| clr_n_i | input | 1 | Asynchronous master clear, active low |
| thr_i | input | 1 | Asynchronous threshold reset, active high |
| trg_n_i | input | 1 | Asynchronous trigger set, active low |
| q_o | output | 1 | Push-pull state output |
| dis_oe_o | output | 1 | Discharge drive-enable, high when pulling low |
| dis_o | output | 1 | Discharge data value, constant 0 |

## Verification
The bench builds the block with the default `SYNC_STAGES = 2`. This makes the full input-to-output delay three clock edges, so the bench can pin down the exact cycle of each change around R10. Random input vectors are held long enough to settle and are run under both captured modes, so the threshold/trigger conflict is exercised from both stored states. Directed sequences cover clear-over-everything, hold after release, and a mode strap toggled outside reset.

// File: rtl/latch_pkg.sv
package latch_pkg;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } latch_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2
    } latch_act_t;

    typedef enum logic {
        MODE_RESET_WINS = 1'b0,
        MODE_SET_WINS   = 1'b1
    } conflict_mode_t;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[0] <= RST_VAL;
                    else     pipe_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[i] <= RST_VAL;
                    else     pipe_q[i] <= pipe_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/prio_decider.sv
module prio_decider
    import latch_pkg::*;
(
    input  logic           clr_n_i,
    input  logic           thr_i,
    input  logic           trg_n_i,
    input  conflict_mode_t mode_i,
    output latch_act_t     act_o
);
    logic trg_act;
    assign trg_act = ~trg_n_i;

    always_comb begin
        if (!clr_n_i) begin
            act_o = ACT_CLEAR;
        end else if (thr_i && trg_act) begin
            act_o = (mode_i == MODE_SET_WINS) ? ACT_SET : ACT_CLEAR;
        end else if (thr_i) begin
            act_o = ACT_CLEAR;
        end else if (trg_act) begin
            act_o = ACT_SET;
        end else begin
            act_o = ACT_HOLD;
        end
    end
endmodule

// File: rtl/latch_fsm.sv
module latch_fsm
    import latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_act_t act_i,
    output logic       q_o,
    output logic       dis_oe_o,
    output logic       dis_o
);
    latch_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (act_i == ACT_SET)   state_d = ST_HIGH;
            ST_HIGH: if (act_i == ACT_CLEAR) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        q_o      = 1'b0;
        dis_oe_o = 1'b1;
        unique case (state_q)
            ST_LOW: begin
                q_o      = 1'b0;
                dis_oe_o = 1'b1;
            end
            ST_HIGH: begin
                q_o      = 1'b1;
                dis_oe_o = 1'b0;
            end
            default: begin
                q_o      = 1'b0;
                dis_oe_o = 1'b1;
            end
        endcase
        dis_o = 1'b0;
    end
endmodule

// File: rtl/prio_sr_latch.sv
module prio_sr_latch
    import latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_i,
    input  logic clr_n_i,
    input  logic thr_i,
    input  logic trg_n_i,
    output logic q_o,
    output logic dis_oe_o,
    output logic dis_o
);
    logic           clr_n_s, thr_s, trg_n_s;
    conflict_mode_t mode_q;
    latch_act_t     act;

    sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
        .clk(clk), .rst(rst), .d_i(clr_n_i), .q_o(clr_n_s)
    );
    sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_thr (
        .clk(clk), .rst(rst), .d_i(thr_i), .q_o(thr_s)
    );
    sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_trg (
        .clk(clk), .rst(rst), .d_i(trg_n_i), .q_o(trg_n_s)
    );

    // Strap register: loads only while reset is held
    always_ff @(posedge clk) begin
        if (rst) mode_q <= conflict_mode_t'(mode_i);
    end

    prio_decider u_dec (
        .clr_n_i(clr_n_s),
        .thr_i  (thr_s),
        .trg_n_i(trg_n_s),
        .mode_i (mode_q),
        .act_o  (act)
    );

    latch_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .q_o     (q_o),
        .dis_oe_o(dis_oe_o),
        .dis_o   (dis_o)
    );
endmodule

// File: rtl/prio_sr_latch_chk.sv
module prio_sr_latch_chk (
    input logic clk,
    input logic rst,
    input logic clr_n_s,
    input logic thr_s,
    input logic trg_n_s,
    input logic mode_q,
    input logic q_o,
    input logic dis_oe_o,
    input logic dis_o
);
    a_r1_reset_low: assert property (@(posedge clk) rst |=> (!q_o && dis_oe_o));

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> !q_o);

    a_r3_thr_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_n_s && thr_s && trg_n_s) |=> !q_o);

    a_r4_trg_sets: assert property (@(posedge clk) disable iff (rst)
        (clr_n_s && !thr_s && !trg_n_s) |=> q_o);

    // R5 and R6: idle inputs keep the state
    a_r5_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_n_s && !thr_s && trg_n_s) |=> $stable(q_o));

    a_r7_reset_wins: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && clr_n_s && thr_s && !trg_n_s) |=> !q_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (mode_q && clr_n_s && thr_s && !trg_n_s) |=> q_o);

    a_r9_discharge: assert property (@(posedge clk)
        (dis_oe_o != q_o) && !dis_o);

    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));
endmodule

bind prio_sr_latch prio_sr_latch_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr_n_s (clr_n_s),
    .thr_s   (thr_s),
    .trg_n_s (trg_n_s),
    .mode_q  (mode_q),
    .q_o     (q_o),
    .dis_oe_o(dis_oe_o),
    .dis_o   (dis_o)
);

// File: tb/tb_prio_sr_latch.sv
module tb_prio_sr_latch;
    localparam int STAGES = 2;
    localparam int LAT    = STAGES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_i = 1'b0;
    logic clr_n_i = 1'b1, thr_i = 1'b0, trg_n_i = 1'b1;
    logic q_o, dis_oe_o, dis_o;

    int checks = 0;
    int errors = 0;
    logic exp_q = 1'b0;
    logic cur_mode = 1'b0;

    always #5 clk = ~clk;

    prio_sr_latch #(.SYNC_STAGES(STAGES)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .clr_n_i(clr_n_i), .thr_i(thr_i), .trg_n_i(trg_n_i),
        .q_o(q_o), .dis_oe_o(dis_oe_o), .dis_o(dis_o)
    );

    function automatic logic model(input logic s, input logic c_n,
                                   input logic t, input logic g_n,
                                   input logic m);
        if (!c_n)           return 1'b0;
        if (t && !g_n)      return m;
        if (t)              return 1'b0;
        if (!g_n)           return 1'b1;
        return s;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, q_o, exp_q);
        chk("R9 dis_oe", dis_oe_o, ~exp_q);
        chk("R9 dis_o", dis_o, 1'b0);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst = 1'b1; mode_i = m;
        clr_n_i = 1'b1; thr_i = 1'b0; trg_n_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", q_o, 1'b0);
        chk("R1 dis in reset", dis_oe_o, 1'b1);
        rst = 1'b0;
        cur_mode = m;
        exp_q = 1'b0;
        @(negedge clk);
        chk("R1 after reset", q_o, 1'b0);
    endtask

    task automatic apply(input logic c_n, input logic t, input logic g_n,
                         input string req);
        clr_n_i = c_n; thr_i = t; trg_n_i = g_n;
        exp_q = model(exp_q, c_n, t, g_n, cur_mode);
        repeat (LAT + 1) @(negedge clk);
        chk_all(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        do_reset(1'b0);

        // R4 then R5: set and hold
        apply(1, 0, 0, "R4 trigger set");
        apply(1, 0, 1, "R5 hold high");
        // R3 then R6
        apply(1, 1, 1, "R3 threshold clear");
        apply(1, 0, 1, "R6 hold low after thr");
        apply(1, 0, 0, "R4 set again");
        apply(0, 0, 0, "R2 clear with trigger");
        apply(1, 0, 1, "R6 hold low after clear");
        // R7 conflict from high state
        apply(1, 0, 0, "R4 set");
        apply(1, 1, 0, "R7 threshold wins");

        // R10 latency: drive at negedge, watch each edge
        apply(1, 0, 1, "R6 idle");
        trg_n_i = 1'b0;
        for (int e = 1; e <= LAT; e++) begin
            @(negedge clk);
            chk("R10 latency", q_o, (e >= LAT) ? 1'b1 : 1'b0);
        end
        exp_q = 1'b1;
        apply(1, 0, 1, "R5 release");

        // R11: strap toggled outside reset is ignored
        apply(1, 1, 1, "R3 clear");
        mode_i = 1'b1;
        apply(1, 1, 0, "R11 mode change ignored");

        // R8 in set-wins mode
        do_reset(1'b1);
        apply(1, 1, 0, "R8 trigger wins");
        apply(0, 1, 0, "R8 clear still overrides");
        apply(1, 1, 1, "R3 threshold clear");
        mode_i = 1'b0;
        apply(1, 1, 0, "R11 set-wins retained");

        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int i = 0; i < 150; i++) begin
                logic [2:0] r;
                r = 3'($urandom);
                mode_i = 1'($urandom);
                apply(r[0] | r[1], r[2], $urandom_range(0, 1) == 0,
                      m == 0 ? "R7 random" : "R8 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule